// File: doc/BRIEF.md
# Four-Phase Link Protocol Monitor

This block is a passive, synthesizable checker placed where a sender hands 32-bit words to a one-word buffer and the buffer hands them on to a receiver. Each side uses a four-phase request/acknowledge handshake. The monitor only watches the two handshake pairs and the two data buses. It never drives them, and it judges cycle order only, not latency.

Each handshake pair goes through a small phase machine. The state register holds the `{req, ack}` pair as it was sampled on the previous clock. The four states are PH_IDLE (00), PH_DONE (01), PH_ASK (10) and PH_GRANT (11). The legal transitions are:

- IDLE to ASK (request raised)
- ASK to GRANT (acknowledge raised)
- GRANT to DONE (request dropped)
- DONE to IDLE (acknowledge dropped)
- staying in the same state

Any other move is flagged by the rule it breaks. A second machine tracks buffer occupancy with the states ORD_EMPTY and ORD_HELD. Its transitions are:

- write acknowledge rises: EMPTY to HELD
- read acknowledge rises: HELD to EMPTY
- write rises while HELD: overflow
- read rises while EMPTY: underflow
- both rise together: the state is kept

A shadow register records the last accepted word, and the word presented to the receiver is compared against it. Every violation sets its own sticky flag, and a combined flag is the OR of all of them.

Top module: `hs_link_monitor`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears every flag and `err_any`. No violation is recorded while `rst` is high.
- R2: A request that is high in this cycle, was low in the previous cycle, and had its acknowledge high in the previous cycle sets flag bit 0 (sender side) or bit 4 (receiver side).
- R3: A request that was high and is now low, while its acknowledge was low in the previous cycle, sets bit 1 (sender side) or bit 5 (receiver side).
- R4: An acknowledge that rises while its request was low in the previous cycle sets bit 2 (sender side) or bit 6 (receiver side).
- R5: An acknowledge that falls while its request was high in the previous cycle sets bit 3 (sender side) or bit 7 (receiver side).
- R6: A rise of `wr_ack` while a word is held (a write accepted with no read rise since) sets bit 8 (overflow).
- R7: A rise of `rd_ack` while no word is held sets bit 9 (underflow). This includes the first read after reset when no write came before it.
- R8: The shadow word is zero after reset and loads `wr_data` on each `wr_ack` rise. On a `rd_ack` rise, `rd_data` different from the shadow word held before that edge sets bit 10.
- R9: Flags stay set until reset, and `err_any` is high exactly when any flag bit is set. A flag appears in the cycle after the edge at which its violation is sampled.
- R10: Edges are found against the value sampled on the previous clock, and that history is cleared by reset. A signal already high in the first cycle after reset therefore counts as rising.
- R11: When `wr_ack` and `rd_ack` rise in the same cycle, neither overflow nor underflow is flagged and the occupancy state is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_req | input | 1 | Sender request to buffer |
| wr_ack | input | 1 | Buffer acknowledge to sender |
| wr_data | input | 32 | Word offered by the sender |
| rd_req | input | 1 | Buffer request to receiver |
| rd_ack | input | 1 | Receiver acknowledge to buffer |
| rd_data | input | 32 | Word offered to the receiver |
| err_flags | output | 11 | Sticky per-rule violation flags, bits as in R2 to R8 |
| err_any | output | 1 | OR of all flags |

## Verification
The phase rules are driven with complete legal handshakes on each side and with single broken steps. Each broken step is reached from the state where it is meant to fire, so that one flag bit separates the four rules per side. Occupancy is tried with these sequences:

- alternating write/read
- a read first after reset
- two writes back to back
- simultaneous rises

Together these separate overflow from underflow and show that simultaneous rises are neutral. Data checking compares a mismatching word against a matching one, and a read of zero straight after reset shows that the shadow word starts at zero. A behavioural model in the bench predicts every flag on every clock.

// File: rtl/hsmon_pkg.sv
`timescale 1ns/1ps
package hsmon_pkg;

    localparam int SIDES      = 2;
    localparam int PAIR_RULES = 4;
    localparam int NUM_FLAGS  = SIDES * PAIR_RULES + 3;

    // flag positions inside one side's group
    localparam int RQ_RISE = 0;
    localparam int RQ_FALL = 1;
    localparam int AK_RISE = 2;
    localparam int AK_FALL = 3;

    // global flag positions
    localparam int FLAG_OVF  = SIDES * PAIR_RULES;
    localparam int FLAG_UDF  = FLAG_OVF + 1;
    localparam int FLAG_DATA = FLAG_OVF + 2;

    // phase encoding is {req, ack} as last sampled
    typedef enum logic [1:0] {
        PH_IDLE  = 2'b00,
        PH_DONE  = 2'b01,
        PH_ASK   = 2'b10,
        PH_GRANT = 2'b11
    } hs_phase_t;

    typedef enum logic {
        ORD_EMPTY = 1'b0,
        ORD_HELD  = 1'b1
    } ord_state_t;

endpackage

// File: rtl/hs_pair_check.sv
`timescale 1ns/1ps
module hs_pair_check
    import hsmon_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req,
    input  logic                  ack,
    output logic [PAIR_RULES-1:0] bad,
    output logic                  ack_rise
);

    hs_phase_t   phase_q;
    logic [1:0]  phase_bits;

    assign phase_bits = phase_q;

    // state register: last sampled {req, ack}
    always_ff @(posedge clk) begin
        if (rst) phase_q <= PH_IDLE;
        else     phase_q <= hs_phase_t'({req, ack});
    end

    // outputs: illegal moves out of each phase
    always_comb begin
        bad = '0;
        unique case (phase_q)
            PH_IDLE:  bad[AK_RISE] = ack;
            PH_ASK:   bad[RQ_FALL] = !req;
            PH_GRANT: bad[AK_FALL] = !ack;
            PH_DONE:  bad[RQ_RISE] = req;
        endcase
    end

    assign ack_rise = ack & ~phase_bits[0];

endmodule

// File: rtl/hs_order_track.sv
`timescale 1ns/1ps
module hs_order_track
    import hsmon_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic wr_rise,
    input  logic rd_rise,
    output logic ovf,
    output logic udf
);

    ord_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= ORD_EMPTY;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        ovf     = 1'b0;
        udf     = 1'b0;
        unique case (state_q)
            ORD_EMPTY: begin
                if (wr_rise && !rd_rise)      state_d = ORD_HELD;
                else if (rd_rise && !wr_rise) udf = 1'b1;
            end
            ORD_HELD: begin
                if (rd_rise && !wr_rise)      state_d = ORD_EMPTY;
                else if (wr_rise && !rd_rise) ovf = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/hs_data_check.sv
`timescale 1ns/1ps
module hs_data_check #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_rise,
    input  logic              rd_rise,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] shadow,
    output logic              mismatch
);

    always_ff @(posedge clk) begin
        if (rst)          shadow <= '0;
        else if (wr_rise) shadow <= wr_data;
    end

    assign mismatch = rd_rise && (rd_data != shadow);

endmodule

// File: rtl/hs_link_monitor.sv
`timescale 1ns/1ps
module hs_link_monitor
    import hsmon_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_req,
    input  logic                 wr_ack,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic                 rd_req,
    input  logic                 rd_ack,
    input  logic [DATA_W-1:0]    rd_data,
    output logic [NUM_FLAGS-1:0] err_flags,
    output logic                 err_any
);

    logic [SIDES-1:0]      req_v, ack_v, rise_v;
    logic [PAIR_RULES-1:0] bad_v [SIDES];
    logic [NUM_FLAGS-1:0]  hit_now, flags_q;
    logic                  ovf, udf, mism;
    logic [DATA_W-1:0]     shadow;

    assign req_v = {rd_req, wr_req};
    assign ack_v = {rd_ack, wr_ack};

    for (genvar s = 0; s < SIDES; s++) begin : g_side
        hs_pair_check u_pair (
            .clk      (clk),
            .rst      (rst),
            .req      (req_v[s]),
            .ack      (ack_v[s]),
            .bad      (bad_v[s]),
            .ack_rise (rise_v[s])
        );
        assign hit_now[s*PAIR_RULES +: PAIR_RULES] = bad_v[s];
    end

    hs_order_track u_order (
        .clk     (clk),
        .rst     (rst),
        .wr_rise (rise_v[0]),
        .rd_rise (rise_v[1]),
        .ovf     (ovf),
        .udf     (udf)
    );

    hs_data_check #(.DATA_W(DATA_W)) u_data (
        .clk      (clk),
        .rst      (rst),
        .wr_rise  (rise_v[0]),
        .rd_rise  (rise_v[1]),
        .wr_data  (wr_data),
        .rd_data  (rd_data),
        .shadow   (shadow),
        .mismatch (mism)
    );

    assign hit_now[FLAG_OVF]  = ovf;
    assign hit_now[FLAG_UDF]  = udf;
    assign hit_now[FLAG_DATA] = mism;

    always_ff @(posedge clk) begin
        if (rst) flags_q <= '0;
        else     flags_q <= flags_q | hit_now;
    end

    assign err_flags = flags_q;
    assign err_any   = |flags_q;

    assert_reset_clear_R1: assert property (@(posedge clk)
        $past(rst) |-> (err_flags == '0 && !err_any));

    assert_req_rise_R2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $rose(wr_req) && $past(wr_ack)) |=> err_flags[RQ_RISE]);

    assert_ack_rise_R4: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $rose(rd_ack) && !$past(rd_req)) |=> err_flags[PAIR_RULES + AK_RISE]);

    assert_shadow_load_R8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$stable(shadow)) |-> $past(rise_v[0]));

    assert_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((err_flags & $past(err_flags)) == $past(err_flags)));

endmodule

// File: tb/test_hs_link_monitor.sv
`timescale 1ns/1ps
module test_hs_link_monitor;

    localparam int NF = 11;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_req = 0, wr_ack = 0, rd_req = 0, rd_ack = 0;
    logic [31:0] wr_data = '0, rd_data = '0;
    logic [NF-1:0] err_flags;
    logic        err_any;

    int checks = 0, errors = 0;
    bit started = 0, done = 0;

    always #5 clk = ~clk;

    hs_link_monitor i_hs_link_monitor (
        .clk(clk), .rst(rst),
        .wr_req(wr_req), .wr_ack(wr_ack), .wr_data(wr_data),
        .rd_req(rd_req), .rd_ack(rd_ack), .rd_data(rd_data),
        .err_flags(err_flags), .err_any(err_any)
    );

    // behavioural reference model
    logic [NF-1:0] m_flags = '0;
    logic          p_wq = 0, p_wa = 0, p_rq = 0, p_ra = 0;
    bit            m_full = 0;
    logic [31:0]   m_word = '0;

    function automatic string tag_of(int b);
        case (b)
            0, 4:    return "R2";
            1, 5:    return "R3";
            2, 6:    return "R4";
            3, 7:    return "R5";
            8:       return "R6";
            9:       return "R7";
            default: return "R8";
        endcase
    endfunction

    always @(posedge clk) begin
        bit wu, ru;
        if (rst) begin
            m_flags = '0; p_wq = 0; p_wa = 0; p_rq = 0; p_ra = 0;
            m_full = 0; m_word = '0;
            started = 1;
        end else begin
            wu = wr_ack && !p_wa;
            ru = rd_ack && !p_ra;
            if (wr_req && !p_wq && p_wa)    m_flags[0] = 1;
            if (!wr_req && p_wq && !p_wa)   m_flags[1] = 1;
            if (wr_ack && !p_wa && !p_wq)   m_flags[2] = 1;
            if (!wr_ack && p_wa && p_wq)    m_flags[3] = 1;
            if (rd_req && !p_rq && p_ra)    m_flags[4] = 1;
            if (!rd_req && p_rq && !p_ra)   m_flags[5] = 1;
            if (rd_ack && !p_ra && !p_rq)   m_flags[6] = 1;
            if (!rd_ack && p_ra && p_rq)    m_flags[7] = 1;
            if (wu && !ru) begin
                if (m_full) m_flags[8] = 1;
                m_full = 1;
            end else if (ru && !wu) begin
                if (!m_full) m_flags[9] = 1;
                m_full = 0;
            end
            if (ru && rd_data != m_word) m_flags[10] = 1;
            if (wu) m_word = wr_data;
            p_wq = wr_req; p_wa = wr_ack; p_rq = rd_req; p_ra = rd_ack;
        end
    end

    // compare model to design every clock, away from the active edge
    always @(negedge clk) begin
        if (started && !done) begin
            for (int b = 0; b < NF; b++) begin
                checks++;
                if (err_flags[b] !== m_flags[b]) begin
                    errors++;
                    $display("FAIL %s: flag bit %0d actual %b expected %b at %0t",
                             tag_of(b), b, err_flags[b], m_flags[b], $time);
                end
            end
            checks++;
            if (err_any !== (|m_flags)) begin
                errors++;
                $display("FAIL R9: err_any actual %b expected %b", err_any, |m_flags);
            end
        end
    end

    task automatic step(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string tag, logic [NF-1:0] exp);
        checks++;
        if (err_flags !== exp || err_any !== (|exp)) begin
            errors++;
            $display("FAIL %s: flags actual %h/%b expected %h/%b",
                     tag, err_flags, err_any, exp, |exp);
        end
    endtask

    task automatic do_reset(logic hold_wack = 0);
        rst = 1; wr_req = 0; wr_ack = hold_wack; rd_req = 0; rd_ack = 0;
        wr_data = '0; rd_data = '0;
        step(2);
        rst = 0;
    endtask

    task automatic put_word(logic [31:0] d);
        wr_data = d; wr_req = 1; step();
        wr_ack = 1; step();
        wr_req = 0; step();
        wr_ack = 0; step();
    endtask

    task automatic get_word(logic [31:0] d);
        rd_data = d; rd_req = 1; step();
        rd_ack = 1; step();
        rd_req = 0; step();
        rd_ack = 0; step();
    endtask

    initial begin
        step();
        do_reset();
        step();
        chk("R1 after reset", '0);

        // R1: violations while reset is high are ignored
        rst = 1; rd_ack = 1; step(); wr_ack = 1; step();
        chk("R1 during reset", '0);
        do_reset(); step();

        // legal alternation, two words (R8 data match)
        put_word(32'hA5A5_1234); get_word(32'hA5A5_1234);
        put_word(32'h0BAD_F00D); get_word(32'h0BAD_F00D);
        step(); chk("R8 legal transfers", '0);

        // R7: read first after reset; data zero matches the zero shadow (R8)
        do_reset(); get_word(32'h0); step();
        chk("R7 underflow first read", 11'h200);

        // R6: two writes back to back
        do_reset(); put_word(32'h1); put_word(32'h2); step();
        chk("R6 overflow", 11'h100);

        // R8: wrong data to receiver
        do_reset(); put_word(32'hCAFE_0001); get_word(32'hCAFE_0002); step();
        chk("R8 data mismatch", 11'h400);

        // R2 sender side: request re-raised while ack still high
        do_reset();
        wr_data = 32'h5; wr_req = 1; step(); wr_ack = 1; step(); wr_req = 0; step();
        wr_req = 1; step(); wr_req = 0; step(); wr_ack = 0; step(2);
        chk("R2 sender request rise", 11'h001);

        // R2 receiver side
        do_reset(); put_word(32'h7);
        rd_data = 32'h7; rd_req = 1; step(); rd_ack = 1; step(); rd_req = 0; step();
        rd_req = 1; step(); rd_req = 0; step(); rd_ack = 0; step(2);
        chk("R2 receiver request rise", 11'h010);

        // R3 both sides: request withdrawn before acknowledge
        do_reset();
        wr_req = 1; step(); wr_req = 0; step(2);
        chk("R3 sender request fall", 11'h002);
        rd_req = 1; step(); rd_req = 0; step(2);
        chk("R3 receiver request fall", 11'h022);

        // R4: acknowledge without request
        do_reset();
        wr_ack = 1; step(); wr_ack = 0; step(2);
        chk("R4 sender ack rise", 11'h004);
        do_reset();
        rd_ack = 1; step(); rd_ack = 0; step(2);
        chk("R4 receiver ack rise plus R7", 11'h240);

        // R5: acknowledge dropped while request high; re-ack is a second write (R6)
        do_reset();
        wr_req = 1; step(); wr_ack = 1; step(); wr_ack = 0; step();
        wr_ack = 1; step(); wr_req = 0; step(); wr_ack = 0; step(2);
        chk("R5 sender ack fall", 11'h108);

        // R11: simultaneous rises are neutral
        do_reset(); put_word(32'h1111_0000);
        wr_data = 32'h2222_0000; rd_data = 32'h1111_0000;
        wr_req = 1; rd_req = 1; step();
        wr_ack = 1; rd_ack = 1; step();
        wr_req = 0; rd_req = 0; step();
        wr_ack = 0; rd_ack = 0; step();
        get_word(32'h2222_0000); step();
        chk("R11 simultaneous rises", '0);

        // R10: acknowledge already high when reset releases counts as a rise
        do_reset(1'b1); step(); wr_ack = 0; step(2);
        chk("R10 history cleared by reset", 11'h004);

        // R9: flags sticky across later legal traffic
        do_reset(); get_word(32'h0);
        for (int k = 0; k < 3; k++) begin
            put_word(32'h100 + k); get_word(32'h100 + k);
        end
        step(); chk("R9 sticky flag", 11'h200);

        step(2);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule